// File: doc/BRIEF.md
# Asynchronous Serial Port with Sticky Status Flags

This block is an asynchronous serial transmitter and receiver with a small register interface. Software writes the line settings into a control register, puts transmit bytes into a data register and watches a status register. A separate transfer-request port lets an external mover put transmit bytes in directly. A frame has one low start bit, eight data bits sent least significant first, an optional extra bit and one high stop bit. The extra bit is either a parity bit or, in multiprocessor format, an address/data marker bit.

The status flags are sticky. Software clears a flag only by reading it as 1 and then writing 0 to it. A parity or framing error stops all later reception until software clears it. A transmit-end flag tells software when the shifter has finished and no further byte is waiting. All flags also drive level interrupt outputs.

Top module: `uart_flag_core`

Registers are selected by `addr`: 0 = data (a write loads the transmit byte, a read returns the received byte), 1 = control, 2 = status. Control bits: bit0 transmit enable, bit1 receive enable, bit2 parity enable, bit3 odd parity (0 = even), bit4 multiprocessor format. Status bits: bit6 transmit-data-empty, bit5 receive-data-full, bit4 framing error, bit3 parity error, bit2 transmit end, bit1 received multiprocessor bit (read-only), bit0 transmit multiprocessor bit (read/write), bit7 reads 0.

## Requirements
- R1: After reset the status register reads 0x44 (transmit-data-empty and transmit end set, all others 0), the control register reads 0 and the serial output is high.
- R2: A transmitted frame is a 0 start bit, the 8 data bits LSB first, then an extra bit when parity or multiprocessor format is on, then a 1 stop bit. Each bit lasts 16 sample ticks. The even parity bit is the XOR of the data bits, and the odd parity bit is its inverse.
- R3: A received frame with a correct extra bit and a high stop bit puts the byte in the data register and sets receive-data-full (bit5).
- R4: With parity on (and multiprocessor format off), a parity mismatch sets the parity error flag (bit3) and moves the byte into the data register, but does not set receive-data-full.
- R5: While the parity error or framing error flag is 1, incoming frames are ignored: the received byte and receive-data-full do not change.
- R6: Bits 6, 5, 4 and 3 clear only when a 0 is written to them after a status read that returned them as 1. A 0 written without that read, or a 1 written, leaves them unchanged.
- R7: Clearing receive enable leaves the parity error flag and the received multiprocessor bit unchanged.
- R8: Transmit end (bit2) is 1 whenever transmit enable is 0. It is also set when the stop bit of a character finishes and transmit-data-empty is 1.
- R9: Transmit end is cleared when software clears transmit-data-empty by the read/write-0 sequence, or when the transfer-request port writes a byte.
- R10: In multiprocessor format the received extra bit is stored in bit1 of a correct frame, and status bit0 is sent as the extra bit of each transmitted frame in place of parity.
- R11: Transmit-data-empty is set when a byte moves into the shifter. A transfer-request write clears it at the same clock edge that loads the byte.
- R12: A received stop bit sampled low sets the framing error flag (bit4) and moves the byte into the data register, but does not set receive-data-full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (arms flag clearing) |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data (combinational) |
| xfer_we | input | 1 | Transfer-request write of transmit data |
| xfer_data | input | 8 | Transfer-request transmit byte |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| irq_rx_full | output | 1 | Level request: receive-data-full |
| irq_tx_empty | output | 1 | Level request: transmit-data-empty while transmit is enabled |
| irq_tx_end | output | 1 | Level request: transmit end |
| irq_err | output | 1 | Level request: parity or framing error |

## Verification
The bench sends frames with good and bad parity of both senses, a low stop bit and multiprocessor markers, and checks the data register and flags after each one. A design that set receive-data-full on a bad frame, or that dropped the byte, fails there. It sends a good frame while an error is pending. A receiver that ignored the sticky error would update the data register. It writes 0 to a flag that software has not yet read, writes 1 to a flag, and turns receive enable off. A design with simple write-to-clear flags, or one that cleared errors when reception stops, changes the flags in these cases. On the transmit side it decodes the serial line and watches transmit end across a software clear, a transfer-request write, the end of a character and a disable in mid-frame. A wrong priority among these set and clear paths leaves transmit end at the wrong level.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;

  localparam int NFLAG = 7;

  // status bit positions
  localparam int ST_MPBT = 0;
  localparam int ST_MPRX = 1;
  localparam int ST_TEND = 2;
  localparam int ST_PERR = 3;
  localparam int ST_FERR = 4;
  localparam int ST_RDRF = 5;
  localparam int ST_TDRE = 6;

  // control bit positions
  localparam int NCTRL     = 5;
  localparam int CT_TXEN   = 0;
  localparam int CT_RXEN   = 1;
  localparam int CT_PAREN  = 2;
  localparam int CT_PARODD = 3;
  localparam int CT_MP     = 4;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  localparam logic [NFLAG-1:0] FL_RESET =
    NFLAG'((1 << ST_TDRE) | (1 << ST_TEND));
  localparam logic [NFLAG-1:0] FL_SWCLR =
    NFLAG'((1 << ST_TDRE) | (1 << ST_RDRF) | (1 << ST_FERR) | (1 << ST_PERR));

  typedef enum logic {LN_IDLE, LN_BUSY} line_state_e;

endpackage

// File: rtl/uart_flag_tick.sv
module uart_flag_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == CW'(DIV - 1));
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/uart_flag_tx.sv
module uart_flag_tx
  import uart_flag_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          tx_en,
  input  logic          tdre,
  input  logic [DW-1:0] tx_data,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          mp_mode,
  input  logic          mpbt,
  output logic          txd,
  output logic          load,
  output logic          dry
);
  localparam int FW = DW + 3;
  localparam int SW = $clog2(OVS);
  localparam int BW = $clog2(FW + 1);

  line_state_e   state_q, state_d;
  logic [FW-1:0] shreg_q, shreg_d;
  logic [SW-1:0] scnt_q, scnt_d;
  logic [BW-1:0] bcnt_q, bcnt_d;
  logic [BW-1:0] len_q, len_d;

  logic          has_x, xbit, bit_end, last_bit;
  logic [FW-1:0] frame;

  always_comb begin
    has_x    = mp_mode | par_en;
    xbit     = mp_mode ? mpbt : ((^tx_data) ^ par_odd);
    frame    = has_x ? {1'b1, xbit, tx_data, 1'b0} : {1'b1, 1'b1, tx_data, 1'b0};
    bit_end  = tick && (scnt_q == SW'(OVS - 1));
    last_bit = (bcnt_q == len_q - 1'b1);

    state_d = state_q;
    shreg_d = shreg_q;
    scnt_d  = scnt_q;
    bcnt_d  = bcnt_q;
    len_d   = len_q;
    load    = 1'b0;
    dry     = 1'b0;

    if (!tx_en) begin
      state_d = LN_IDLE;
    end else if (state_q == LN_IDLE) begin
      load = !tdre;
    end else if (bit_end) begin
      if (last_bit) begin
        if (!tdre) begin
          load = 1'b1;
        end else begin
          dry     = 1'b1;
          state_d = LN_IDLE;
        end
      end else begin
        shreg_d = {1'b1, shreg_q[FW-1:1]};
        bcnt_d  = bcnt_q + 1'b1;
        scnt_d  = '0;
      end
    end else if (tick) begin
      scnt_d = scnt_q + 1'b1;
    end

    if (load) begin
      state_d = LN_BUSY;
      shreg_d = frame;
      scnt_d  = '0;
      bcnt_d  = '0;
      len_d   = has_x ? BW'(FW) : BW'(FW - 1);
    end

    txd = (state_q == LN_BUSY) ? shreg_q[0] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LN_IDLE;
      shreg_q <= '1;
      scnt_q  <= '0;
      bcnt_q  <= '0;
      len_q   <= '0;
    end else begin
      state_q <= state_d;
      shreg_q <= shreg_d;
      scnt_q  <= scnt_d;
      bcnt_q  <= bcnt_d;
      len_q   <= len_d;
    end
  end
endmodule

// File: rtl/uart_flag_rx.sv
module uart_flag_rx
  import uart_flag_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx,
  input  logic          enable,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          mp_mode,
  output logic          done_ok,
  output logic          done_perr,
  output logic          done_ferr,
  output logic [DW-1:0] data,
  output logic          xbit
);
  localparam int SW  = $clog2(OVS);
  localparam int BW  = $clog2(DW + 3);
  localparam int MID = OVS / 2;

  line_state_e   state_q, state_d;
  logic [SW-1:0] scnt_q, scnt_d;
  logic [BW-1:0] bcnt_q, bcnt_d;
  logic [1:0]    votes_q, votes_d;
  logic [DW-1:0] data_q, data_d;
  logic          xbit_q, xbit_d;

  logic          has_x, in_win, decide, wrap, bitval, par_bad;
  logic [1:0]    vsum;
  logic [BW-1:0] last_idx;

  always_comb begin
    has_x    = mp_mode | par_en;
    last_idx = has_x ? BW'(DW + 2) : BW'(DW + 1);
    in_win   = (scnt_q >= SW'(MID - 1)) && (scnt_q <= SW'(MID + 1));
    decide   = (scnt_q == SW'(MID + 1));
    wrap     = (scnt_q == SW'(OVS - 1));
    vsum     = votes_q + {1'b0, rx};
    bitval   = vsum[1];
    par_bad  = par_en && !mp_mode && (xbit_q != ((^data_q) ^ par_odd));

    state_d   = state_q;
    scnt_d    = scnt_q;
    bcnt_d    = bcnt_q;
    votes_d   = votes_q;
    data_d    = data_q;
    xbit_d    = xbit_q;
    done_ok   = 1'b0;
    done_perr = 1'b0;
    done_ferr = 1'b0;

    if (state_q == LN_IDLE) begin
      if (enable && !rx) begin
        state_d = LN_BUSY;
        scnt_d  = '0;
        bcnt_d  = '0;
        votes_d = '0;
      end
    end else if (!enable) begin
      state_d = LN_IDLE;
    end else if (tick) begin
      scnt_d = wrap ? '0 : scnt_q + 1'b1;
      if (wrap) begin
        bcnt_d  = bcnt_q + 1'b1;
        votes_d = '0;
      end else if (in_win) begin
        votes_d = vsum;
      end
      if (decide) begin
        if (bcnt_q == '0) begin
          if (bitval) state_d = LN_IDLE;
        end else if (bcnt_q <= BW'(DW)) begin
          data_d = {bitval, data_q[DW-1:1]};
        end else if (bcnt_q == last_idx) begin
          state_d   = LN_IDLE;
          done_ferr = !bitval;
          done_perr = par_bad;
          done_ok   = bitval && !par_bad;
        end else begin
          xbit_d = bitval;
        end
      end
    end
  end

  assign data = data_q;
  assign xbit = xbit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LN_IDLE;
      scnt_q  <= '0;
      bcnt_q  <= '0;
      votes_q <= '0;
      data_q  <= '0;
      xbit_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      scnt_q  <= scnt_d;
      bcnt_q  <= bcnt_d;
      votes_q <= votes_d;
      data_q  <= data_d;
      xbit_q  <= xbit_d;
    end
  end
endmodule

// File: rtl/uart_flag_regs.sv
module uart_flag_regs
  import uart_flag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_rd,
  input  logic             st_wr,
  input  logic [NFLAG-1:0] wdata,
  input  logic             tx_en,
  input  logic             mp_mode,
  input  logic             tx_load,
  input  logic             tx_dry,
  input  logic             xfer_we,
  input  logic             rx_ok,
  input  logic             rx_perr,
  input  logic             rx_ferr,
  input  logic             rx_mpb,
  output logic [NFLAG-1:0] flags
);
  logic [NFLAG-1:0] flags_q, flags_d;
  logic [NFLAG-1:0] seen_q, seen_d;
  logic [NFLAG-1:0] clr;

  always_comb begin
    flags_d = flags_q;
    clr     = st_wr ? (~wdata & seen_q & flags_q & FL_SWCLR) : '0;

    if (xfer_we)           flags_d[ST_TDRE] = 1'b0;
    else if (tx_load)      flags_d[ST_TDRE] = 1'b1;
    else if (clr[ST_TDRE]) flags_d[ST_TDRE] = 1'b0;

    if (!tx_en)                        flags_d[ST_TEND] = 1'b1;
    else if (xfer_we || clr[ST_TDRE])  flags_d[ST_TEND] = 1'b0;
    else if (tx_dry)                   flags_d[ST_TEND] = 1'b1;

    if (rx_ok)             flags_d[ST_RDRF] = 1'b1;
    else if (clr[ST_RDRF]) flags_d[ST_RDRF] = 1'b0;

    if (rx_perr)           flags_d[ST_PERR] = 1'b1;
    else if (clr[ST_PERR]) flags_d[ST_PERR] = 1'b0;

    if (rx_ferr)           flags_d[ST_FERR] = 1'b1;
    else if (clr[ST_FERR]) flags_d[ST_FERR] = 1'b0;

    if (rx_ok && mp_mode)  flags_d[ST_MPRX] = rx_mpb;

    if (st_wr)             flags_d[ST_MPBT] = wdata[ST_MPBT];

    seen_d = (seen_q | (st_rd ? flags_q : '0)) & flags_d & FL_SWCLR;
  end

  assign flags = flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= FL_RESET;
      seen_q  <= '0;
    end else begin
      flags_q <= flags_d;
      seen_q  <= seen_d;
    end
  end
endmodule

// File: rtl/uart_flag_core.sv
module uart_flag_core
  import uart_flag_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16,
  parameter int DIV = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          xfer_we,
  input  logic [DW-1:0] xfer_data,
  input  logic          rxd_i,
  output logic          txd_o,
  output logic          irq_rx_full,
  output logic          irq_tx_empty,
  output logic          irq_tx_end,
  output logic          irq_err
);
  logic [1:0]       rst_pipe_q;
  logic             rst_s;
  logic [1:0]       rx_pipe_q;
  logic [NCTRL-1:0] ctrl_q, ctrl_d;
  logic [DW-1:0]    txdata_q, txdata_d;
  logic [DW-1:0]    rxdata_q, rxdata_d;
  logic [NFLAG-1:0] status_w;

  logic tick, st_rd, st_wr, rx_en_eff;
  logic tx_load, tx_dry;
  logic rx_ok, rx_perr, rx_ferr, rx_xbit;
  logic [DW-1:0] rx_byte;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s = rst_pipe_q[1];

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) rx_pipe_q <= '1;
    else        rx_pipe_q <= {rx_pipe_q[0], rxd_i};
  end

  always_comb begin
    st_rd     = rd_en && (addr == A_STAT);
    st_wr     = wr_en && (addr == A_STAT);
    rx_en_eff = ctrl_q[CT_RXEN] && !status_w[ST_PERR] && !status_w[ST_FERR];

    ctrl_d = (wr_en && (addr == A_CTRL)) ? wdata[NCTRL-1:0] : ctrl_q;

    if (xfer_we)                         txdata_d = xfer_data;
    else if (wr_en && (addr == A_DATA))  txdata_d = wdata;
    else                                 txdata_d = txdata_q;

    rxdata_d = (rx_ok || rx_perr || rx_ferr) ? rx_byte : rxdata_q;

    case (addr)
      A_DATA:  rdata = rxdata_q;
      A_CTRL:  rdata = DW'(ctrl_q);
      A_STAT:  rdata = DW'(status_w);
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ctrl_q   <= '0;
      txdata_q <= '0;
      rxdata_q <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      txdata_q <= txdata_d;
      rxdata_q <= rxdata_d;
    end
  end

  uart_flag_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_s), .tick(tick)
  );

  uart_flag_tx #(.DW(DW), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_s), .tick(tick),
    .tx_en(ctrl_q[CT_TXEN]), .tdre(status_w[ST_TDRE]), .tx_data(txdata_q),
    .par_en(ctrl_q[CT_PAREN]), .par_odd(ctrl_q[CT_PARODD]), .mp_mode(ctrl_q[CT_MP]),
    .mpbt(status_w[ST_MPBT]), .txd(txd_o), .load(tx_load), .dry(tx_dry)
  );

  uart_flag_rx #(.DW(DW), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_s), .tick(tick), .rx(rx_pipe_q[1]), .enable(rx_en_eff),
    .par_en(ctrl_q[CT_PAREN]), .par_odd(ctrl_q[CT_PARODD]), .mp_mode(ctrl_q[CT_MP]),
    .done_ok(rx_ok), .done_perr(rx_perr), .done_ferr(rx_ferr),
    .data(rx_byte), .xbit(rx_xbit)
  );

  uart_flag_regs u_flags (
    .clk(clk), .rst_n(rst_s), .st_rd(st_rd), .st_wr(st_wr),
    .wdata(wdata[NFLAG-1:0]), .tx_en(ctrl_q[CT_TXEN]), .mp_mode(ctrl_q[CT_MP]),
    .tx_load(tx_load), .tx_dry(tx_dry), .xfer_we(xfer_we),
    .rx_ok(rx_ok), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_mpb(rx_xbit),
    .flags(status_w)
  );

  assign irq_rx_full  = status_w[ST_RDRF];
  assign irq_tx_empty = status_w[ST_TDRE] && ctrl_q[CT_TXEN];
  assign irq_tx_end   = status_w[ST_TEND];
  assign irq_err      = status_w[ST_PERR] || status_w[ST_FERR];
endmodule

// File: rtl/uart_flag_core_chk.sv
module uart_flag_core_chk
  import uart_flag_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic             xfer_we,
  input logic             txd_o,
  input logic [NCTRL-1:0] ctrl,
  input logic [NFLAG-1:0] status
);
  logic st_wr;
  assign st_wr = wr_en && (addr == A_STAT);

  p_idle_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[CT_TXEN] |=> txd_o);

  p_bad_parity_not_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[ST_PERR]) |-> !$rose(status[ST_RDRF]));

  p_perr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_PERR] && !st_wr) |=> status[ST_PERR]);

  p_rx_off_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[CT_RXEN] && !st_wr) |=> ($stable(status[ST_PERR]) && $stable(status[ST_MPRX])));

  p_tend_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[CT_TXEN] |=> status[ST_TEND]);

  p_xfer_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_we && ctrl[CT_TXEN] && !wr_en) |=> (!status[ST_TDRE] && !status[ST_TEND]));
endmodule

bind uart_flag_core uart_flag_core_chk u_chk (
  .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .addr(addr), .xfer_we(xfer_we),
  .txd_o(txd_o), .ctrl(ctrl_q), .status(status_w)
);

// File: tb/uart_flag_core_test.sv
`timescale 1ns/1ps
module uart_flag_core_test;
  localparam int BIT = 32;  // 16 samples x 2 clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       xfer_we = 1'b0;
  logic [7:0] xfer_data = '0;
  logic       rxd_i = 1'b1;
  logic       txd_o, irq_rx_full, irq_tx_empty, irq_tx_end, irq_err;

  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  uart_flag_core uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .xfer_we(xfer_we), .xfer_data(xfer_data),
    .rxd_i(rxd_i), .txd_o(txd_o), .irq_rx_full(irq_rx_full),
    .irq_tx_empty(irq_tx_empty), .irq_tx_end(irq_tx_end), .irq_err(irq_err)
  );

  typedef struct packed {
    logic [7:0] data;
    logic [4:0] ctrl;
    logic       xb;
    logic       stop;
    logic [7:0] exp_rx;
    logic [3:0] exp_fl;  // {full, ferr, perr, mprx}
  } vec_t;

  localparam vec_t VECS [0:8] = '{
    '{8'hA5, 5'h02, 1'b0, 1'b1, 8'hA5, 4'b1000},  // R3 plain
    '{8'h3C, 5'h06, 1'b0, 1'b1, 8'h3C, 4'b1000},  // R3 even ok
    '{8'h3C, 5'h06, 1'b1, 1'b1, 8'h3C, 4'b0010},  // R4 even bad
    '{8'h81, 5'h0E, 1'b1, 1'b1, 8'h81, 4'b1000},  // R3 odd ok
    '{8'h81, 5'h0E, 1'b0, 1'b1, 8'h81, 4'b0010},  // R4 odd bad
    '{8'h5A, 5'h02, 1'b0, 1'b0, 8'h5A, 4'b0100},  // R12 low stop
    '{8'h7E, 5'h12, 1'b1, 1'b1, 8'h7E, 4'b1001},  // R10 marker 1
    '{8'h11, 5'h12, 1'b0, 1'b1, 8'h11, 4'b1000},  // R10 marker 0
    '{8'hFF, 5'h16, 1'b1, 1'b1, 8'hFF, 4'b1001}   // R10 overrides parity
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic cpu_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic has_x, input logic xb, input logic stop);
    @(negedge clk);
    rxd_i = 1'b0; repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd_i = d[i]; repeat (BIT) @(negedge clk); end
    if (has_x) begin rxd_i = xb; repeat (BIT) @(negedge clk); end
    rxd_i = stop; repeat (BIT) @(negedge clk);
    rxd_i = 1'b1; repeat (BIT) @(negedge clk);
  endtask

  task automatic capture(input int nb, output logic [10:0] bits, output logic end_mid, output logic empty_mid);
    bits = '1;
    while (txd_o !== 1'b0) @(negedge clk);
    repeat (BIT / 2) @(negedge clk);
    end_mid = irq_tx_end; empty_mid = irq_tx_empty;
    bits[0] = txd_o;
    for (int i = 1; i < nb; i++) begin
      repeat (BIT) @(negedge clk);
      bits[i] = txd_o;
    end
  endtask

  task automatic xfer(input logic [7:0] d, output logic empty_after, output logic end_after);
    @(negedge clk); xfer_data = d; xfer_we = 1'b1;
    @(posedge clk); #1 empty_after = irq_tx_empty; end_after = irq_tx_end;
    @(negedge clk); xfer_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  r;
    logic [10:0] bits;
    logic        em, en;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    cpu_rd(2'd2, r); chk("R1 status", r, 8'h44);
    cpu_rd(2'd1, r); chk("R1 ctrl", r, 8'h00);
    chk("R1 txd idle", txd_o, 1'b1);

    // receive vector table
    foreach (VECS[k]) begin
      cpu_wr(2'd1, {3'b0, VECS[k].ctrl});
      send_frame(VECS[k].data, VECS[k].ctrl[2] | VECS[k].ctrl[4], VECS[k].xb, VECS[k].stop);
      cpu_rd(2'd0, r); chk($sformatf("R3/R4/R12 vec%0d data", k), r, VECS[k].exp_rx);
      cpu_rd(2'd2, r);
      chk($sformatf("R3/R4/R10/R12 vec%0d flags", k), {r[5], r[4], r[3], r[1]}, VECS[k].exp_fl);
      cpu_wr(2'd2, 8'h44);
    end

    // R5: pending parity error blocks reception
    cpu_wr(2'd1, 8'h06);
    send_frame(8'h3C, 1'b1, 1'b1, 1'b1);
    chk("R4 irq_err", irq_err, 1'b1);
    send_frame(8'h99, 1'b1, 1'b0, 1'b1);
    cpu_rd(2'd0, r); chk("R5 data kept", r, 8'h3C);
    cpu_rd(2'd2, r); chk("R5 full/perr", {r[5], r[3]}, 2'b01);

    // R7: receive disable keeps perr and marker
    cpu_wr(2'd1, 8'h00);
    cpu_rd(2'd2, r); chk("R7 perr/mprx kept", {r[3], r[1]}, 2'b11);
    cpu_wr(2'd2, 8'h44);
    cpu_rd(2'd2, r); chk("R6 cleared after read", r[3], 1'b0);

    // R6: write 0 without read, write 1
    cpu_wr(2'd1, 8'h06);
    send_frame(8'h3C, 1'b1, 1'b1, 1'b1);
    cpu_wr(2'd2, 8'h44);
    cpu_rd(2'd2, r); chk("R6 zero w/o read", r[3], 1'b1);
    cpu_wr(2'd2, 8'h4C);
    cpu_rd(2'd2, r); chk("R6 write one", r[3], 1'b1);
    cpu_wr(2'd2, 8'h44);
    cpu_rd(2'd2, r); chk("R6 read then zero", r[3], 1'b0);

    // transmit: software path
    cpu_wr(2'd1, 8'h01);
    chk("R8 tend before send", irq_tx_end, 1'b1);
    cpu_wr(2'd0, 8'hC3);
    cpu_rd(2'd2, r);
    cpu_wr(2'd2, 8'h04);
    capture(10, bits, en, em);
    chk("R9 tend cleared", en, 1'b0);
    chk("R11 empty after load", em, 1'b1);
    chk("R2 frame C3", bits[9:0], {1'b1, 8'hC3, 1'b0});
    repeat (BIT) @(negedge clk);
    chk("R8 tend at dry", irq_tx_end, 1'b1);

    // transmit: transfer request, even parity
    cpu_wr(2'd1, 8'h05);
    xfer(8'h5A, em, en);
    chk("R11 xfer clears empty", em, 1'b0);
    chk("R9 xfer clears tend", en, 1'b0);
    capture(11, bits, en, em);
    chk("R2 frame 5A even", bits, {1'b1, 1'b0, 8'h5A, 1'b0});

    // odd parity
    repeat (BIT) @(negedge clk);
    cpu_wr(2'd1, 8'h0D);
    xfer(8'h5A, em, en);
    capture(11, bits, en, em);
    chk("R2 frame 5A odd", bits, {1'b1, 1'b1, 8'h5A, 1'b0});

    // R10 transmit marker bit
    repeat (BIT) @(negedge clk);
    cpu_wr(2'd1, 8'h11);
    cpu_wr(2'd2, 8'h45);
    xfer(8'h0F, em, en);
    capture(11, bits, en, em);
    chk("R10 marker sent", bits, {1'b1, 1'b1, 8'h0F, 1'b0});

    // R8 disable mid-frame
    repeat (BIT) @(negedge clk);
    cpu_wr(2'd1, 8'h01);
    xfer(8'h00, em, en);
    repeat (50) @(negedge clk);
    chk("R9 tend low mid-frame", irq_tx_end, 1'b0);
    cpu_wr(2'd1, 8'h00);
    repeat (2) @(negedge clk);
    chk("R8 tend on disable", irq_tx_end, 1'b1);
    chk("R8 line idle", txd_o, 1'b1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule